// File: doc/BRIEF.md
# Serial Command Receiver and Register File

This block is the write-only front end of a multiplexed LED display controller. A host drives a three-wire serial link (serial clock, active-low select, data) and sends 16-bit command words, most significant bit first. The upper byte of each word chooses a target and the lower byte carries its value. The block brings the three serial lines into the system clock domain and detects their edges there. It collects bits while select is low and acts on the word when select returns high.

The targets are five control registers: the per-digit decode mask, brightness, the last scanned digit, the configuration, and the lamp-test flag. The other targets are two 8-byte digit planes that a display scanner reads through an index port. A configuration word can also request two one-shot actions. One resets the scan and blink timers. The other wipes both planes. Each appears as a single-cycle strobe and neither is stored.

Top module: `ser_cmd_regs`

## Requirements
- R1: A word is 16 bits sent MSB first. Bits 15..8 are the target address and bits 7..0 are the value. A bit is taken on each rising serial clock edge while `ser_cs_n` is low.
- R2: Serial clock and data activity while `ser_cs_n` is high changes neither the shift contents nor any output.
- R3: When `ser_cs_n` rises, the most recent 16 received bits are executed, whatever the frame length. A short frame completes its word with bits left over from earlier frames.
- R4: After reset: decode mask 0x00, brightness 0, last scanned digit 4, shutdown (`run_normal`=0), slow blink, blink disabled, lamp test off, every byte of both planes 0, no strobes.
- R5: Address 0x01 loads the whole value into the decode mask. 0x02 loads value bits 3..0 into brightness. 0x03 loads value bits 2..0 into the last scanned digit. 0x07 loads value bit 0 into lamp test.
- R6: Address 0x04 stores value bit 0 as `run_normal` (1 = running), bit 2 as `blink_fast` (1 = fast) and bit 3 as `blink_en`.
- R7: Address 0x04 with value bit 4 set gives exactly one cycle of `timing_clr`. Bit 4 on any other address gives no strobe.
- R8: Address 0x04 with value bit 5 set gives exactly one cycle of `data_clr` and zeroes all bytes of both planes. From the cycle the strobe is high, every plane byte reads 0.
- R9: Address 0x20+i writes digit i (0..7) of plane 0 only, 0x40+i writes plane 1 only, and 0x60+i writes the same byte to both planes.
- R10: Any other address (for example 0x00, 0x06, 0x28, 0x80) changes no register, no plane byte and no strobe.
- R11: Every register and plane can be written while `run_normal` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial clock, asynchronous, at least 4x slower than clk |
| ser_cs_n | input | 1 | Serial select, active low |
| ser_din | input | 1 | Serial data |
| scan_idx | input | 3 | Digit index for the scanner read port |
| dec_mask | output | 8 | Per-digit decode enable |
| bright | output | 4 | Brightness code |
| scan_last | output | 3 | Index of the last scanned digit |
| run_normal | output | 1 | 1 = running, 0 = shutdown |
| blink_fast | output | 1 | 1 = fast blink rate |
| blink_en | output | 1 | Global blink enable |
| test_on | output | 1 | Lamp test active |
| plane0_byte | output | 8 | Plane 0 byte at scan_idx |
| plane1_byte | output | 8 | Plane 1 byte at scan_idx |
| timing_clr | output | 1 | One-cycle strobe to reset scan and blink timers |
| data_clr | output | 1 | One-cycle strobe marking a wipe of both planes |

## Verification
The bench sends frames longer and shorter than 16 bits. A receiver that reset its shift register on select falling, or that counted bits, would load the wrong target or none. Clock pulses sent with select high are followed by a short frame whose result depends on the leftover bits, so a receiver that kept shifting while deselected would write the wrong register. Action bits are sent on both the configuration address and a digit address, and the strobe scoreboard catches a strobe that is missing, extra or stretched. Plane-selective writes, writes to unlisted addresses and writes during shutdown are followed by a readback of all sixteen plane bytes through the scanner port, which exposes a write to the wrong plane or a missed write.

// File: rtl/ser_cmd_pkg.sv
package ser_cmd_pkg;
    localparam int WORD_W   = 16;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = WORD_W - ADDR_W;
    localparam int DIGITS   = 8;
    localparam int IDX_W    = $clog2(DIGITS);
    localparam int BRIGHT_W = 4;
    localparam int SYNC_N   = 2;

    localparam logic [ADDR_W-1:0] A_DECODE = 8'h01;
    localparam logic [ADDR_W-1:0] A_BRIGHT = 8'h02;
    localparam logic [ADDR_W-1:0] A_SCAN   = 8'h03;
    localparam logic [ADDR_W-1:0] A_CONFIG = 8'h04;
    localparam logic [ADDR_W-1:0] A_TEST   = 8'h07;

    localparam logic [IDX_W-1:0] SCAN_RESET = 3'd4;

    // Configuration bit positions inside the value byte
    localparam int CB_RUN   = 0;
    localparam int CB_FAST  = 2;
    localparam int CB_BLINK = 3;
    localparam int CB_TCLR  = 4;
    localparam int CB_WIPE  = 5;

    typedef struct packed {
        logic run;
        logic fast;
        logic blink;
    } cfg_t;
endpackage

// File: rtl/serial_front.sv
// serial_front: brings the three asynchronous serial lines into the clk
// domain through SYNC_N-flop chains and turns them into events.
// Assumes ser_clk is at least 4x slower than clk, so no edge is missed.
// All three lines see the same latency, which keeps their order intact.
module serial_front
    import ser_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_cs_n,
    input  logic ser_din,
    output logic bit_valid,
    output logic bit_val,
    output logic frame_end
);
    localparam int LINES = 3;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic [LINES-1:0] prev;

    assign raw = {ser_din, ser_cs_n, ser_clk};

    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_sync
            logic [SYNC_N-1:0] chain;
            // Per-line synchronizer chain; select resets high (idle)
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= (g == 1) ? '1 : '0;
                else        chain <= {chain[SYNC_N-2:0], raw[g]};
            end
            assign synced[g] = chain[SYNC_N-1];
        end
    endgenerate

    // Previous synchronized levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 3'b010;
        else        prev <= synced;
    end

    assign bit_valid = synced[0] & ~prev[0] & ~synced[1];
    assign bit_val   = synced[2];
    assign frame_end = synced[1] & ~prev[1];
endmodule

// File: rtl/frame_shifter.sv
// frame_shifter: WORD_W-bit shift register, MSB first. It is never
// cleared between frames, so a short frame is completed by leftover bits.
module frame_shifter
    import ser_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_valid,
    input  logic              bit_val,
    output logic [WORD_W-1:0] word
);
    // Shift one bit in at the low end on each accepted serial edge
    always_ff @(posedge clk) begin
        if (!rst_n)         word <= '0;
        else if (bit_valid) word <= {word[WORD_W-2:0], bit_val};
    end
endmodule

// File: rtl/cmd_decoder.sv
// cmd_decoder: executes a word on frame_end. It holds the control
// registers, drives the combinational plane write/wipe controls, and
// registers the one-cycle action strobes. Unlisted addresses do nothing.
module cmd_decoder
    import ser_cmd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_end,
    input  logic [WORD_W-1:0]   word,
    output logic [DIGITS-1:0]   dec_mask,
    output logic [BRIGHT_W-1:0] bright,
    output logic [IDX_W-1:0]    scan_last,
    output cfg_t                cfg,
    output logic                test_on,
    output logic                we0,
    output logic                we1,
    output logic [IDX_W-1:0]    widx,
    output logic [DATA_W-1:0]   wdata,
    output logic                wipe,
    output logic                timing_clr,
    output logic                data_clr
);
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] val;
    logic              is_cfg;
    logic              is_digit;

    assign addr = word[WORD_W-1:DATA_W];
    assign val  = word[DATA_W-1:0];

    // Decode the target class of the pending word
    always_comb begin
        is_cfg   = frame_end && (addr == A_CONFIG);
        is_digit = frame_end && !addr[7] && (addr[6:5] != 2'b00)
                   && (addr[4:IDX_W] == '0);
        we0      = is_digit && addr[5];
        we1      = is_digit && addr[6];
        widx     = addr[IDX_W-1:0];
        wdata    = val;
        wipe     = is_cfg && val[CB_WIPE];
    end

    // Control register file, loaded by a matching address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_mask  <= '0;
            bright    <= '0;
            scan_last <= SCAN_RESET;
            cfg       <= '{run: 1'b0, fast: 1'b0, blink: 1'b0};
            test_on   <= 1'b0;
        end else if (frame_end) begin
            case (addr)
                A_DECODE: dec_mask  <= val;
                A_BRIGHT: bright    <= val[BRIGHT_W-1:0];
                A_SCAN:   scan_last <= val[IDX_W-1:0];
                A_CONFIG: cfg       <= '{run:   val[CB_RUN],
                                         fast:  val[CB_FAST],
                                         blink: val[CB_BLINK]};
                A_TEST:   test_on   <= val[0];
                default: ;
            endcase
        end
    end

    // Single-cycle action strobes, not stored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timing_clr <= 1'b0;
            data_clr   <= 1'b0;
        end else begin
            timing_clr <= is_cfg && val[CB_TCLR];
            data_clr   <= wipe;
        end
    end
endmodule

// File: rtl/digit_planes.sv
// digit_planes: two banks of DIGITS bytes with a combined write port
// (per-plane enables) and a global wipe that has priority. The read
// port for the scanner is combinational.
module digit_planes
    import ser_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we0,
    input  logic              we1,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wipe,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rd0,
    output logic [DATA_W-1:0] rd1
);
    logic [DATA_W-1:0] bank0 [DIGITS];
    logic [DATA_W-1:0] bank1 [DIGITS];

    genvar d;
    generate
        for (d = 0; d < DIGITS; d++) begin : g_byte
            logic hit;
            assign hit = (widx == IDX_W'(d));
            // One byte of each plane: reset/wipe to zero, else write on hit
            always_ff @(posedge clk) begin
                if (!rst_n || wipe) begin
                    bank0[d] <= '0;
                    bank1[d] <= '0;
                end else begin
                    if (we0 && hit) bank0[d] <= wdata;
                    if (we1 && hit) bank1[d] <= wdata;
                end
            end
        end
    endgenerate

    assign rd0 = bank0[ridx];
    assign rd1 = bank1[ridx];
endmodule

// File: rtl/ser_cmd_regs.sv
// ser_cmd_regs: top of the serial command receiver and register file.
// Chain: serial_front -> frame_shifter -> cmd_decoder -> digit_planes.
// A register changes three clk edges after ser_cs_n rises at the pin.
module ser_cmd_regs
    import ser_cmd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ser_clk,
    input  logic                ser_cs_n,
    input  logic                ser_din,
    input  logic [IDX_W-1:0]    scan_idx,
    output logic [DIGITS-1:0]   dec_mask,
    output logic [BRIGHT_W-1:0] bright,
    output logic [IDX_W-1:0]    scan_last,
    output logic                run_normal,
    output logic                blink_fast,
    output logic                blink_en,
    output logic                test_on,
    output logic [DATA_W-1:0]   plane0_byte,
    output logic [DATA_W-1:0]   plane1_byte,
    output logic                timing_clr,
    output logic                data_clr
);
    logic              bit_valid, bit_val, frame_end;
    logic [WORD_W-1:0] word;
    cfg_t              cfg;
    logic              we0, we1, wipe;
    logic [IDX_W-1:0]  widx;
    logic [DATA_W-1:0] wdata;

    serial_front u_front (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_cs_n(ser_cs_n),
        .ser_din(ser_din), .bit_valid(bit_valid), .bit_val(bit_val),
        .frame_end(frame_end)
    );

    frame_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_val(bit_val),
        .word(word)
    );

    cmd_decoder u_dec (
        .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .word(word),
        .dec_mask(dec_mask), .bright(bright), .scan_last(scan_last),
        .cfg(cfg), .test_on(test_on), .we0(we0), .we1(we1), .widx(widx),
        .wdata(wdata), .wipe(wipe), .timing_clr(timing_clr),
        .data_clr(data_clr)
    );

    digit_planes u_planes (
        .clk(clk), .rst_n(rst_n), .we0(we0), .we1(we1), .widx(widx),
        .wdata(wdata), .wipe(wipe), .ridx(scan_idx), .rd0(plane0_byte),
        .rd1(plane1_byte)
    );

    assign run_normal = cfg.run;
    assign blink_fast = cfg.fast;
    assign blink_en   = cfg.blink;
endmodule

// File: rtl/ser_cmd_regs_chk.sv
// ser_cmd_regs_chk: temporal checks on the top-level ports, bound below.
module ser_cmd_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ser_cs_n,
    input logic [7:0] dec_mask,
    input logic [3:0] bright,
    input logic [2:0] scan_last,
    input logic       run_normal,
    input logic       blink_fast,
    input logic       blink_en,
    input logic       test_on,
    input logic [7:0] plane0_byte,
    input logic [7:0] plane1_byte,
    input logic       timing_clr,
    input logic       data_clr
);
    logic [2:0] age;

    // Cycles since reset, saturating, so $past never reaches before reset
    always_ff @(posedge clk) begin
        if (!rst_n)         age <= '0;
        else if (age != 3'd7) age <= age + 3'd1;
    end

    // R7: the timing strobe lasts exactly one cycle
    p_tclr_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        timing_clr |=> !timing_clr);

    // R8: the wipe strobe lasts exactly one cycle
    p_wipe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        data_clr |=> !data_clr);

    // R8: planes read zero while the wipe strobe is high
    p_wipe_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        data_clr |-> (plane0_byte == 8'h00 && plane1_byte == 8'h00));

    // R2/R3: no register moves while select has been low for 4 cycles
    p_hold_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 3'd5 && !$past(ser_cs_n, 1) && !$past(ser_cs_n, 2)
         && !$past(ser_cs_n, 3) && !$past(ser_cs_n, 4))
        |-> $stable({dec_mask, bright, scan_last, run_normal, blink_fast,
                     blink_en, test_on}));

    // R7/R8: strobes never fire while select has been low for 4 cycles
    p_no_strobe_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 3'd5 && !$past(ser_cs_n, 1) && !$past(ser_cs_n, 2)
         && !$past(ser_cs_n, 3) && !$past(ser_cs_n, 4))
        |-> (!timing_clr && !data_clr));
endmodule

bind ser_cmd_regs ser_cmd_regs_chk u_chk (.*);

// File: tb/sim_ser_cmd_regs.sv
module sim_ser_cmd_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_cs_n = 1'b1;
    logic       ser_din = 1'b0;
    logic [2:0] scan_idx = 3'd0;
    logic [7:0] dec_mask, plane0_byte, plane1_byte;
    logic [3:0] bright;
    logic [2:0] scan_last;
    logic       run_normal, blink_fast, blink_en, test_on;
    logic       timing_clr, data_clr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Model state computed from the requirements
    logic [7:0] m_dec;
    logic [3:0] m_bri;
    logic [2:0] m_scan;
    logic       m_run, m_fast, m_blink, m_test;
    logic [7:0] m_p0 [8];
    logic [7:0] m_p1 [8];
    logic [15:0] m_shift;

    // Scoreboard of expected strobes: {timing_clr, data_clr}
    logic [1:0] exp_q [$];

    always #10 clk = ~clk;

    ser_cmd_regs u0 (.*);

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Apply the requirements to the model for an executed word
    task automatic model_exec(input logic [15:0] w);
        logic [7:0] a, v;
        a = w[15:8];
        v = w[7:0];
        case (a)
            8'h01: m_dec = v;
            8'h02: m_bri = v[3:0];
            8'h03: m_scan = v[2:0];
            8'h07: m_test = v[0];
            8'h04: begin
                m_run = v[0]; m_fast = v[2]; m_blink = v[3];
                if (v[5]) for (int i = 0; i < 8; i++) begin
                    m_p0[i] = 8'h00; m_p1[i] = 8'h00;
                end
                if (v[4] || v[5]) exp_q.push_back({v[4], v[5]});
            end
            default: begin
                if (a[7:3] == 5'b00100 || a[7:3] == 5'b01100) m_p0[a[2:0]] = v;
                if (a[7:3] == 5'b01000 || a[7:3] == 5'b01100) m_p1[a[2:0]] = v;
            end
        endcase
    endtask

    // Send n bits (MSB of the n first) in one select-low frame
    task automatic send(input int n, input logic [31:0] bits);
        ser_cs_n = 1'b0;
        #100;
        for (int i = n - 1; i >= 0; i--) begin
            ser_din = bits[i];
            #100 ser_clk = 1'b1;
            m_shift = {m_shift[14:0], bits[i]};
            #100 ser_clk = 1'b0;
        end
        #100 ser_cs_n = 1'b1;
        model_exec(m_shift);
        #200;
    endtask

    task automatic word(input logic [15:0] w);
        send(16, {16'h0, w});
    endtask

    // Compare every output and all plane bytes against the model
    task automatic check_all(input string req);
        @(negedge clk);
        chk(req, "dec_mask", {8'h0, dec_mask}, {8'h0, m_dec});
        chk(req, "bright", {12'h0, bright}, {12'h0, m_bri});
        chk(req, "scan_last", {13'h0, scan_last}, {13'h0, m_scan});
        chk(req, "cfg", {13'h0, run_normal, blink_fast, blink_en},
            {13'h0, m_run, m_fast, m_blink});
        chk(req, "test_on", {15'h0, test_on}, {15'h0, m_test});
        for (int i = 0; i < 8; i++) begin
            scan_idx = 3'(i);
            #1;
            chk(req, $sformatf("plane0[%0d]", i), {8'h0, plane0_byte}, {8'h0, m_p0[i]});
            chk(req, $sformatf("plane1[%0d]", i), {8'h0, plane1_byte}, {8'h0, m_p1[i]});
        end
    endtask

    // Monitor: pop an expected strobe for every strobe observed
    always @(negedge clk) begin
        if (rst_n && (timing_clr || data_clr)) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R7/R8 strobe actual=%b%b expected=none",
                         timing_clr, data_clr);
            end else begin
                logic [1:0] e;
                e = exp_q.pop_front();
                if ({timing_clr, data_clr} !== e) begin
                    errors++;
                    $display("FAIL R7/R8 strobe actual=%b%b expected=%b",
                             timing_clr, data_clr, e);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m_dec = 8'h00; m_bri = 4'h0; m_scan = 3'd4;
        m_run = 1'b0; m_fast = 1'b0; m_blink = 1'b0; m_test = 1'b0;
        m_shift = 16'h0000;
        for (int i = 0; i < 8; i++) begin m_p0[i] = 8'h00; m_p1[i] = 8'h00; end

        repeat (4) @(posedge clk);
        #3 rst_n = 1'b1;
        repeat (4) @(posedge clk);

        // R4: reset state
        check_all("R4");
        chk("R4", "strobes idle", {14'h0, timing_clr, data_clr}, 16'h0);

        // R11: writes while in shutdown; R5 registers
        word(16'h01A5);
        word(16'h0209);
        word(16'h0302);
        word(16'h0701);
        check_all("R5_R11");
        word(16'h02F6);   // R5: only low nibble kept
        word(16'h03FD);   // R5: only low 3 bits kept
        check_all("R5");

        // R9: plane-selective digit writes (R11: still in shutdown)
        word(16'h2011);
        word(16'h4722);
        word(16'h6333);
        word(16'h2744);
        word(16'h4055);
        check_all("R9_R11");

        // R6: configuration storage, no actions
        word(16'h040D);
        check_all("R6");
        word(16'h0401);
        check_all("R6");

        // R10: unlisted addresses
        word(16'h00FF);
        word(16'h06FF);
        word(16'h28FF);
        word(16'h80FF);
        word(16'hE3FF);
        check_all("R10");

        // R7: timing strobe only on the configuration address
        word(16'h0411);
        check_all("R7");
        word(16'h2130);   // bits 4/5 on a digit address: no strobe
        check_all("R7_R9");

        // R8: wipe both planes plus timing strobe in one word
        word(16'h043D);
        check_all("R8");
        word(16'h6577);
        check_all("R8_R9");

        // R3: long frame keeps last 16 bits
        send(20, 32'h000A_0206);
        check_all("R3");
        // R3: short frame completes with leftover bits -> word 0x0603? no:
        // leftover low byte 0x06 becomes address; value 0x01 -> unlisted
        send(8, 32'h0000_0001);
        check_all("R3");
        word(16'h1003);   // leftover 0x03 as address
        send(8, 32'h0000_0005);   // word 0x0305: scan_last = 5
        check_all("R3");

        // R2: activity with select high is ignored
        for (int i = 0; i < 8; i++) begin
            ser_din = 1'b1;
            #100 ser_clk = 1'b1;
            #100 ser_clk = 1'b0;
        end
        #200;
        check_all("R2");
        send(8, 32'h0000_0003);   // word {0x05,0x03}? leftover is 0x05 -> 0x0503
        check_all("R2");
        word(16'h1002);
        ser_din = 1'b1;
        for (int i = 0; i < 8; i++) begin
            #100 ser_clk = 1'b1;
            #100 ser_clk = 1'b0;
        end
        #200;
        send(8, 32'h0000_000C);   // word 0x020C if nothing shifted while high
        check_all("R2_R1");

        // R1: MSB-first ordering of a mixed pattern
        word(16'h0196);
        check_all("R1");

        repeat (10) @(posedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R7/R8 missing strobes actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule